// File: doc/BRIEF.md
# Control-Word Driven 4-Bit Datapath

This block is the execution half of a small multi-cycle processor. It holds four 4-bit scratch registers, reads two of them at once, runs one of them (and either a second register or an immediate constant) through a function unit made of an adder/logic stage and a shifter, and writes a result back to one register on the next rising clock edge. Every cycle the sequencer in front of it supplies one packed 14-bit control word that sets all of these choices together.

The first read port drives the memory address output. The second operand bus, after the constant/register selection, drives the memory write-data output. The value written back is either the function result or the word arriving from memory. The function unit also reports overflow, carry, negative and zero flags for the current cycle, so that the sequencer can branch on them.

Reads, the function unit and the flags are combinational. The only state is the register file. Its reset is asserted asynchronously and released in step with the clock.

Top module: `dp_core`

## Requirements
- R1: After reset every register holds 0, and reading any of them with the pass-A code gives 0 with the zero flag high.
- R2: The control word is decoded by bit position: 13-12 destination register, 11-10 first read register, 9-8 second read register, 7 operand-B source, 6-2 function code, 1 write-back source, 0 write enable.
- R3: `addr_out` always equals the register chosen by bits 11-10.
- R4: `data_out` equals `const_in` when bit 7 is 1, and the register chosen by bits 9-8 when bit 7 is 0. This same value is operand B of the function unit.
- R5: When bit 0 is 1, the register chosen by bits 13-12 is loaded on the rising edge. It takes the function result when bit 1 is 0 and `data_in` when bit 1 is 1.
- R6: When bit 0 is 0, no register changes, whatever the other fields hold.
- R7: The arithmetic codes compute A (00000), A+1 (00001), A+B (00010), A+~B+1 (00101) and A-1 (00110), all modulo 16.
- R8: The logic codes compute A AND B (01000), A OR B (01010), A XOR B (01100) and NOT A (01110).
- R9: Codes 10000, 10100 and 11000 give B, B shifted right by one and B shifted left by one. The vacated bit is 0.
- R10: For codes whose bits 4-3 are 00, C is the carry out of the 4-bit sum and V is set when the sum overflows as a signed value. For all other codes both are 0.
- R11: N equals bit 3 of the function result, and Z is high exactly when the result is 0.
- R12: A register written in a cycle still shows its old value on the read ports during that cycle. The new value appears only after the clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; register writes on the rising edge |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| ctrl_word | input | 14 | Packed control word for the current cycle |
| const_in | input | 4 | Immediate operand, usable as operand B |
| data_in | input | 4 | Word read from memory, usable as write-back value |
| addr_out | output | 4 | Memory address, taken from read port A |
| data_out | output | 4 | Memory write data, taken from operand bus B |
| flag_v | output | 1 | Signed overflow of the arithmetic result |
| flag_c | output | 1 | Carry out of the arithmetic result |
| flag_n | output | 1 | Most significant bit of the function result |
| flag_z | output | 1 | Function result equals zero |

## Verification
The bench builds the block with its default parameters: 4-bit data words and a 2-bit register address. With those widths every register is visited, and each carry and overflow boundary can be reached with only a few operands: 7+1, 15+1, 8-1 and 1-7. A reference model in the bench computes the expected bus and flag values for every control word. A pseudo-random run over all twelve function codes then mixes writes from the constant input and from memory with suppressed writes.

// File: rtl/dp_pkg.sv
package dp_pkg;
  localparam int FSW = 5;

  localparam logic [FSW-1:0] FN_PASS_A = 5'b00000;
  localparam logic [FSW-1:0] FN_INC    = 5'b00001;
  localparam logic [FSW-1:0] FN_ADD    = 5'b00010;
  localparam logic [FSW-1:0] FN_SUB    = 5'b00101;
  localparam logic [FSW-1:0] FN_DEC    = 5'b00110;
  localparam logic [FSW-1:0] FN_AND    = 5'b01000;
  localparam logic [FSW-1:0] FN_OR     = 5'b01010;
  localparam logic [FSW-1:0] FN_XOR    = 5'b01100;
  localparam logic [FSW-1:0] FN_NOT    = 5'b01110;
  localparam logic [FSW-1:0] FN_PASS_B = 5'b10000;
  localparam logic [FSW-1:0] FN_SHR    = 5'b10100;
  localparam logic [FSW-1:0] FN_SHL    = 5'b11000;

  // operand-B conditioning inside the adder, chosen by code bits 2-1
  typedef enum logic [1:0] {
    BOP_ZERO = 2'b00,
    BOP_TRUE = 2'b01,
    BOP_INV  = 2'b10,
    BOP_ONES = 2'b11
  } bop_e;

  // logic operation, chosen by code bits 2-1
  typedef enum logic [1:0] {
    LOP_AND = 2'b00,
    LOP_OR  = 2'b01,
    LOP_XOR = 2'b10,
    LOP_NOT = 2'b11
  } lop_e;

  // shift operation, chosen by code bits 3-2
  typedef enum logic [1:0] {
    SOP_PASS  = 2'b00,
    SOP_RIGHT = 2'b01,
    SOP_LEFT  = 2'b10,
    SOP_PASS2 = 2'b11
  } sop_e;
endpackage

// File: rtl/dp_regfile.sv
module dp_regfile #(
  parameter int DW = 4,
  parameter int RA = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [RA-1:0] wsel,
  input  logic [DW-1:0] wdata,
  input  logic [RA-1:0] rsel_a,
  input  logic [RA-1:0] rsel_b,
  output logic [DW-1:0] rdata_a,
  output logic [DW-1:0] rdata_b
);
  localparam int NREG = 1 << RA;

  logic [DW-1:0] store [NREG];
  logic [NREG-1:0] load_en;

  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      load_en[i] = we && (wsel == RA'(i));
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        store[g] <= '0;
      end else if (load_en[g]) begin
        store[g] <= wdata;
      end
    end
  end

  assign rdata_a = store[rsel_a];
  assign rdata_b = store[rsel_b];
endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_pkg::*;
#(
  parameter int DW = 4
) (
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  input  logic [3:0]    sel,
  output logic [DW-1:0] res,
  output logic          cout,
  output logic          ovf
);
  logic [DW-1:0] bmod;
  logic [DW:0]   sum;
  logic [DW-1:0] lres;
  logic          arith;

  assign arith = ~sel[3];

  always_comb begin
    unique case (bop_e'(sel[2:1]))
      BOP_ZERO: bmod = '0;
      BOP_TRUE: bmod = opb;
      BOP_INV:  bmod = ~opb;
      default:  bmod = '1;
    endcase
    sum = {1'b0, opa} + {1'b0, bmod} + (DW+1)'(sel[0]);
  end

  always_comb begin
    unique case (lop_e'(sel[2:1]))
      LOP_AND: lres = opa & opb;
      LOP_OR:  lres = opa | opb;
      LOP_XOR: lres = opa ^ opb;
      default: lres = ~opa;
    endcase
  end

  assign res  = arith ? sum[DW-1:0] : lres;
  assign cout = arith & sum[DW];
  assign ovf  = arith & (opa[DW-1] == bmod[DW-1]) & (sum[DW-1] != opa[DW-1]);
endmodule

// File: rtl/dp_shifter.sv
module dp_shifter
  import dp_pkg::*;
#(
  parameter int DW = 4
) (
  input  logic [DW-1:0] din,
  input  logic [1:0]    sel,
  output logic [DW-1:0] dout
);
  always_comb begin
    unique case (sop_e'(sel))
      SOP_RIGHT: dout = {1'b0, din[DW-1:1]};
      SOP_LEFT:  dout = {din[DW-2:0], 1'b0};
      default:   dout = din;
    endcase
  end
endmodule

// File: rtl/dp_funit.sv
module dp_funit
  import dp_pkg::*;
#(
  parameter int DW = 4
) (
  input  logic [DW-1:0]  opa,
  input  logic [DW-1:0]  opb,
  input  logic [FSW-1:0] fsel,
  output logic [DW-1:0]  res,
  output logic           fv,
  output logic           fc,
  output logic           fn,
  output logic           fz
);
  logic [DW-1:0] alu_res;
  logic [DW-1:0] sh_res;
  logic          alu_c;
  logic          alu_v;
  logic          use_sh;

  dp_alu #(.DW(DW)) u_alu (
    .opa  (opa),
    .opb  (opb),
    .sel  (fsel[3:0]),
    .res  (alu_res),
    .cout (alu_c),
    .ovf  (alu_v)
  );

  dp_shifter #(.DW(DW)) u_sh (
    .din  (opb),
    .sel  (fsel[3:2]),
    .dout (sh_res)
  );

  assign use_sh = fsel[FSW-1];
  assign res    = use_sh ? sh_res : alu_res;
  assign fc     = ~use_sh & alu_c;
  assign fv     = ~use_sh & alu_v;
  assign fn     = res[DW-1];
  assign fz     = (res == '0);
endmodule

// File: rtl/dp_core.sv
module dp_core
  import dp_pkg::*;
#(
  parameter int DW = 4,
  parameter int RA = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [3*RA+7:0]     ctrl_word,
  input  logic [DW-1:0]       const_in,
  input  logic [DW-1:0]       data_in,
  output logic [DW-1:0]       addr_out,
  output logic [DW-1:0]       data_out,
  output logic                flag_v,
  output logic                flag_c,
  output logic                flag_n,
  output logic                flag_z
);
  localparam int CW     = 3*RA + 8;
  localparam int DST_HI = CW - 1;
  localparam int ASL_HI = DST_HI - RA;
  localparam int BSL_HI = ASL_HI - RA;
  localparam int MB_BIT = 7;
  localparam int FS_HI  = 6;
  localparam int MD_BIT = 1;
  localparam int RW_BIT = 0;

  logic [1:0]     rst_pipe;
  logic           rst_q_n;
  logic [RA-1:0]  dst_sel, a_sel, b_sel;
  logic           b_const, wb_mem, wr_en;
  logic [FSW-1:0] fsel;
  logic [DW-1:0]  bus_a, reg_b, bus_b, fres, wb_val;

  // reset asserted at once, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_q_n = rst_pipe[1];

  // control word decode
  assign dst_sel = ctrl_word[DST_HI -: RA];
  assign a_sel   = ctrl_word[ASL_HI -: RA];
  assign b_sel   = ctrl_word[BSL_HI -: RA];
  assign b_const = ctrl_word[MB_BIT];
  assign fsel    = ctrl_word[FS_HI -: FSW];
  assign wb_mem  = ctrl_word[MD_BIT];
  assign wr_en   = ctrl_word[RW_BIT];

  dp_regfile #(.DW(DW), .RA(RA)) u_rf (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .we      (wr_en),
    .wsel    (dst_sel),
    .wdata   (wb_val),
    .rsel_a  (a_sel),
    .rsel_b  (b_sel),
    .rdata_a (bus_a),
    .rdata_b (reg_b)
  );

  assign bus_b = b_const ? const_in : reg_b;

  dp_funit #(.DW(DW)) u_fu (
    .opa  (bus_a),
    .opb  (bus_b),
    .fsel (fsel),
    .res  (fres),
    .fv   (flag_v),
    .fc   (flag_c),
    .fn   (flag_n),
    .fz   (flag_z)
  );

  assign wb_val   = wb_mem ? data_in : fres;
  assign addr_out = bus_a;
  assign data_out = bus_b;
endmodule

// File: rtl/dp_core_chk.sv
module dp_core_chk #(
  parameter int DW = 4,
  parameter int RA = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic [3*RA+7:0] ctrl,
  input logic [DW-1:0]   const_in,
  input logic [DW-1:0]   data_in,
  input logic [DW-1:0]   addr_out,
  input logic [DW-1:0]   data_out,
  input logic            flag_v,
  input logic            flag_c,
  input logic            flag_n,
  input logic            flag_z
);
  localparam int CW     = 3*RA + 8;
  localparam int DST_HI = CW - 1;
  localparam int ASL_HI = DST_HI - RA;

  logic [RA-1:0] c_dst, c_asel;
  logic [4:0]    c_fs;
  assign c_dst  = ctrl[DST_HI -: RA];
  assign c_asel = ctrl[ASL_HI -: RA];
  assign c_fs   = ctrl[6:2];

  // R5: a memory write-back is seen on read port A after the edge
  assert_mem_writeback_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(ctrl[0]) && $past(ctrl[1]) && (c_asel == $past(c_dst)))
    |-> (addr_out == $past(data_in)));

  // R6: with writes off, a register read twice in a row is unchanged
  assert_no_write_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(ctrl[0]) && (c_asel == $past(c_asel)))
    |-> (addr_out == $past(addr_out)));

  // R4: constant source reaches the data output
  assert_const_path_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[7] |-> (data_out == const_in));

  // R10: carry and overflow stay low outside the arithmetic group
  assert_flags_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (c_fs[4:3] != 2'b00) |-> (!flag_c && !flag_v));

  // R11: on pass-A the flags describe the address bus value
  assert_zero_neg_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (c_fs == 5'b00000) |-> ((flag_z == (addr_out == '0)) && (flag_n == addr_out[DW-1])));
endmodule

bind dp_core dp_core_chk #(.DW(DW), .RA(RA)) u_chk (
  .clk      (clk),
  .rst_n    (rst_q_n),
  .ctrl     (ctrl_word),
  .const_in (const_in),
  .data_in  (data_in),
  .addr_out (addr_out),
  .data_out (data_out),
  .flag_v   (flag_v),
  .flag_c   (flag_c),
  .flag_n   (flag_n),
  .flag_z   (flag_z)
);

// File: tb/sim_dp_core.sv
`timescale 1ns/1ps
module sim_dp_core;
  logic        clk;
  logic        rst_n;
  logic [13:0] ctrl_word;
  logic [3:0]  const_in, data_in;
  logic [3:0]  addr_out, data_out;
  logic        flag_v, flag_c, flag_n, flag_z;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [3:0] a;
    logic [3:0] b;
    logic v, c, n, z;
    string tag;
  } exp_t;

  exp_t sb[$];
  event go;
  logic [3:0] mdl [4];

  dp_core u0 (
    .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .const_in(const_in),
    .data_in(data_in), .addr_out(addr_out), .data_out(data_out),
    .flag_v(flag_v), .flag_c(flag_c), .flag_n(flag_n), .flag_z(flag_z)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  // reference from the function-code table of the requirements
  function automatic void ref_fn(input logic [4:0] fs, input logic [3:0] a,
                                 input logic [3:0] b, output logic [3:0] f,
                                 output logic c, output logic v);
    logic [4:0] s;
    c = 0; v = 0; f = 0;
    case (fs)
      5'b00000: f = a;
      5'b00001: begin s = a + 5'd1; f = s[3:0]; c = s[4]; v = (a == 4'h7); end
      5'b00010: begin s = a + b; f = s[3:0]; c = s[4]; v = (a[3] == b[3]) && (f[3] != a[3]); end
      5'b00101: begin s = {1'b0, a} + {1'b0, ~b} + 5'd1; f = s[3:0]; c = s[4];
                      v = (a[3] != b[3]) && (f[3] != a[3]); end
      5'b00110: begin s = a + 5'd15; f = s[3:0]; c = s[4]; v = (a == 4'h8); end
      5'b01000: f = a & b;
      5'b01010: f = a | b;
      5'b01100: f = a ^ b;
      5'b01110: f = ~a;
      5'b10000: f = b;
      5'b10100: f = b >> 1;
      5'b11000: f = b << 1;
      default:  f = 0;
    endcase
  endfunction

  task automatic drive(input logic [1:0] da, input logic [1:0] aa, input logic [1:0] ba,
                       input logic mb, input logic [4:0] fs, input logic md, input logic rw,
                       input logic [3:0] k, input logic [3:0] d, input string tag);
    exp_t e;
    logic [3:0] f;
    logic c, v;
    @(negedge clk);
    ctrl_word = {da, aa, ba, mb, fs, md, rw};
    const_in  = k;
    data_in   = d;
    e.a = mdl[aa];
    e.b = mb ? k : mdl[ba];
    ref_fn(fs, e.a, e.b, f, c, v);
    e.v = v; e.c = c; e.n = f[3]; e.z = (f == 0); e.tag = tag;
    sb.push_back(e);
    ->go;
    if (rw) mdl[da] = md ? d : f;
  endtask

  // monitor: compares outputs one step after each new control word
  initial begin
    forever begin
      @(go);
      #1;
      while (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (addr_out !== e.a || data_out !== e.b || flag_v !== e.v ||
            flag_c !== e.c || flag_n !== e.n || flag_z !== e.z) begin
          errors++;
          $display("FAIL %s: got a=%h b=%h vcnz=%b%b%b%b expected a=%h b=%h vcnz=%b%b%b%b",
                   e.tag, addr_out, data_out, flag_v, flag_c, flag_n, flag_z,
                   e.a, e.b, e.v, e.c, e.n, e.z);
        end
      end
    end
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  localparam logic [4:0] PA = 5'b00000, INC = 5'b00001, ADD = 5'b00010, SUB = 5'b00101,
                         DEC = 5'b00110, AND_ = 5'b01000, OR_ = 5'b01010, XOR_ = 5'b01100,
                         NOT_ = 5'b01110, PB = 5'b10000, SHR = 5'b10100, SHL = 5'b11000;

  initial begin
    logic [4:0] codes [12];
    logic [15:0] lf;
    codes = '{PA, INC, ADD, SUB, DEC, AND_, OR_, XOR_, NOT_, PB, SHR, SHL};
    for (int i = 0; i < 4; i++) mdl[i] = 0;
    rst_n = 0; ctrl_word = 0; const_in = 0; data_in = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (3) @(posedge clk);

    // R1 reset contents, R3 each read address
    for (int i = 0; i < 4; i++) drive(0, 2'(i), 0, 0, PA, 0, 0, 0, 0, "R1_R3");

    // R5 loads through function result and through memory data
    drive(0, 0, 0, 1, PB, 0, 1, 4'h7, 4'h0, "R4_R5");
    drive(1, 0, 0, 0, PA, 1, 1, 4'h0, 4'h1, "R5");
    drive(2, 1, 0, 0, PA, 1, 1, 4'h0, 4'hF, "R5");
    drive(3, 2, 0, 1, PB, 0, 1, 4'h8, 4'h0, "R4_R5");
    for (int i = 0; i < 4; i++) drive(0, 2'(i), 2'(i), 0, PA, 0, 0, 4'h3, 0, "R3_R4");

    // R12 same-cycle read shows old value, new one after the edge
    drive(0, 0, 0, 1, PB, 0, 1, 4'h3, 0, "R12");
    drive(0, 0, 0, 0, PA, 0, 0, 0, 0, "R12");
    drive(0, 0, 0, 1, PB, 0, 1, 4'h7, 0, "R12");

    // R7 R10 R11 arithmetic with boundaries
    drive(0, 0, 1, 0, ADD, 0, 0, 0, 0, "R7_R10 7+1");
    drive(0, 2, 1, 0, ADD, 0, 0, 0, 0, "R10_R11 F+1");
    drive(0, 0, 0, 0, INC, 0, 0, 0, 0, "R7_R10 inc7");
    drive(0, 2, 0, 0, INC, 0, 0, 0, 0, "R10_R11 incF");
    drive(0, 3, 0, 0, DEC, 0, 0, 0, 0, "R7_R10 dec8");
    drive(0, 1, 0, 0, SUB, 0, 0, 0, 0, "R7_R10 1-7");
    drive(0, 0, 1, 0, SUB, 0, 0, 0, 0, "R7_R10 7-1");
    drive(0, 3, 1, 0, SUB, 0, 0, 0, 0, "R7_R10 8-1");
    drive(0, 1, 1, 0, SUB, 0, 0, 0, 0, "R11 zero");

    // R8 logic, R10 flags quiet
    drive(0, 2, 0, 0, AND_, 0, 0, 0, 0, "R8");
    drive(0, 0, 3, 0, OR_, 0, 0, 0, 0, "R8");
    drive(0, 0, 2, 0, XOR_, 0, 0, 0, 0, "R8_R11");
    drive(0, 0, 0, 0, NOT_, 0, 0, 0, 0, "R8");
    drive(0, 2, 0, 0, NOT_, 0, 0, 0, 0, "R8_R11");

    // R9 shifts with zero fill
    drive(0, 0, 0, 1, SHR, 0, 0, 4'h9, 0, "R9");
    drive(0, 0, 0, 1, SHL, 0, 0, 4'h9, 0, "R9");
    drive(0, 0, 3, 0, PB, 0, 0, 0, 0, "R9");

    // R6 suppressed write, then read back
    drive(0, 1, 0, 0, PA, 1, 0, 0, 4'h5, "R6");
    drive(0, 0, 0, 0, PA, 0, 0, 0, 0, "R6");

    // R2 all fields distinct in one word
    drive(2, 1, 3, 0, ADD, 0, 1, 4'h2, 4'h4, "R2");
    drive(0, 2, 1, 0, PA, 0, 0, 0, 0, "R2");

    // R7 mixed pseudo-random run
    lf = 16'hACE1;
    for (int n = 0; n < 300; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      drive(lf[1:0], lf[3:2], lf[5:4], lf[6], codes[int'(lf[15:8]) % 12],
            lf[7], lf[8] | lf[9], lf[11:8], lf[15:12], "R7_mix");
    end

    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule